// File: doc/BRIEF.md
# PCIe Function Error Logger

This block collects error events for one PCIe function that lives inside a switch port. It keeps an advanced-error-reporting style status vector and a single header-log slot. The slot captures the 128-bit header of the first loggable error and holds it until software acknowledges that error. A packet that trips several checks in the same cycle is reduced to its single highest-ranked error, which is the pollution rule. Errors that have no packet behind them, such as a completion timeout or an internal fault, bypass that reduction. A legacy detected-parity flag sits next to the status vector and sees every poisoned packet, whatever the pollution outcome.

The same block tracks the DMA channels of the function. A channel goes busy when it is started. If a failed completion comes back for one of its reads, the channel drops to idle and latches a reason bit. There is one bit for a completer abort on a descriptor fetch and one for an unsupported-request completion on a data read. An aborted channel cannot be restarted until software clears its reason bits. All status bits are cleared by writing one.

Top module: `fn_err_log`

## Requirements
- R1: After reset, `aer_sts`, `dpe`, `hdr_valid`, `ch_busy`, `ch_desc_ca` and `ch_data_ca` are all zero.
- R2: Bit positions of `ev_kind` and `aer_sts` are: 0 unsupported request, 1 unexpected completion, 2 poisoned, 3 ECRC, 4 malformed, 5 completion timeout, 6 internal error. Bits 0 to 4 are packet errors. Within one `ev_valid` cycle, only the highest-ranked packet error sets its status bit. The ranking is malformed, then ECRC, then unsupported request, then unexpected completion, then poisoned.
- R3: Completion timeout (bit 5) and internal error (bit 6) set their status bits on every occurrence, whatever packet errors arrive in the same cycle.
- R4: While `hdr_valid` is 0, a winning packet error with `ev_on_link`=1 captures `ev_hdr` into `hdr_log` and its bit index into `first_err` one cycle later. While `hdr_valid` is 1, later errors leave `hdr_log` and `first_err` unchanged.
- R5: A packet error with `ev_on_link`=0, and a completion timeout, update `aer_sts` but never capture a header.
- R6: An internal error with no header held and no on-link packet capture in the same cycle sets `hdr_valid`, sets `first_err`=6 and fills `hdr_log` with all ones.
- R7: `dpe` is set by any event that has bit 2 set, even when a higher-ranked error wins pollution. `dpe_clr` clears it.
- R8: `aer_clr_we` clears the `aer_sts` bits set in `aer_clr_mask`. A bit that is set in the same cycle stays set.
- R9: `ch_start[i]` makes channel i busy one cycle later, provided both of its reason bits are clear.
- R10: A completion with `cpl_status`=2 (completer abort) and `cpl_kind`=0 (descriptor read) for a busy channel sets `ch_desc_ca` and clears `ch_busy` for that channel.
- R11: A completion with `cpl_status`=1 (unsupported request) and `cpl_kind`=1 (data read) for a busy channel sets `ch_data_ca` and clears `ch_busy` for that channel.
- R12: Any other completion (status 0, completer abort on a data read, unsupported request on a descriptor read), and any completion for an idle channel, changes no channel state.
- R13: `ch_clr_we` with `ch_clr_sel` clears the selected channel's reason bits: `ch_clr_mask` bit 0 clears the descriptor bit and bit 1 clears the data bit. An aborted channel ignores `ch_start` until both bits are clear.
- R14: Clearing the `aer_sts` bit named by `first_err` drops `hdr_valid`, so the next loggable error can capture a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Error event strobe |
| ev_kind | input | 7 | Error types present in this event |
| ev_on_link | input | 1 | Offending packet arrived on the link |
| ev_hdr | input | HW | Header of the offending packet |
| aer_clr_we | input | 1 | Write-one-to-clear strobe for the status vector |
| aer_clr_mask | input | 7 | Status bits to clear |
| dpe_clr | input | 1 | Clear the legacy parity flag |
| cpl_valid | input | 1 | Completion result strobe |
| cpl_status | input | 2 | 0 success, 1 unsupported request, 2 completer abort |
| cpl_chan | input | CW | Channel that owns the read |
| cpl_kind | input | 1 | 0 descriptor read, 1 data read |
| ch_start | input | NCH | Per-channel start request |
| ch_clr_we | input | 1 | Channel status clear strobe |
| ch_clr_sel | input | CW | Channel to clear |
| ch_clr_mask | input | 2 | Bit 0 descriptor reason, bit 1 data reason |
| aer_sts | output | 7 | Error status vector |
| dpe | output | 1 | Legacy detected-parity flag |
| hdr_valid | output | 1 | Header slot holds a header |
| first_err | output | 3 | Index of the error that owns the header |
| hdr_log | output | HW | Logged header |
| ch_busy | output | NCH | Channel is processing |
| ch_desc_ca | output | NCH | Descriptor-read completer abort seen |
| ch_data_ca | output | NCH | Data-read failure seen |

## Verification
The bench sends events that stack unsupported request, unexpected completion and poisoned together. A design with the ranking wrong would set more than one packet bit, or the wrong bit, and would also drop the parity flag. It sends a second error while a header is held, to catch a design that overwrites the slot. It sends an off-link error and a timeout, to catch a design that logs a header without a received packet. It also sets and clears the same status bit in one cycle. On the channel side it sends mismatched completion kinds, completions for idle channels, and a restart before the clear. A design that aborts on the wrong pairing, or that revives an aborted channel, shows the wrong busy or reason bits.

// File: rtl/fel_pkg.sv
package fel_pkg;
    localparam int NKIND = 7;
    localparam int KW    = $clog2(NKIND);

    typedef enum logic [KW-1:0] {
        K_UR   = 3'd0,
        K_UC   = 3'd1,
        K_PSN  = 3'd2,
        K_ECRC = 3'd3,
        K_MAL  = 3'd4,
        K_CTO  = 3'd5,
        K_INT  = 3'd6
    } kind_e;

    localparam logic [NKIND-1:0] PKT_MASK =
        NKIND'((1 << K_UR) | (1 << K_UC) | (1 << K_PSN) | (1 << K_ECRC) | (1 << K_MAL));

    localparam logic [1:0] CPL_SC = 2'd0;
    localparam logic [1:0] CPL_UR = 2'd1;
    localparam logic [1:0] CPL_CA = 2'd2;

    localparam logic RD_DESC = 1'b0;
    localparam logic RD_DATA = 1'b1;
endpackage

// File: rtl/fel_pollute.sv
module fel_pollute
    import fel_pkg::*;
(
    input  logic [NKIND-1:0] kinds,
    output logic [NKIND-1:0] keep,
    output logic             pkt_hit,
    output logic [KW-1:0]    pkt_idx
);
    localparam int NRANK = 5;
    localparam kind_e RANK [NRANK] = '{K_MAL, K_ECRC, K_UR, K_UC, K_PSN};

    always_comb begin
        keep    = kinds & ~PKT_MASK;
        pkt_hit = 1'b0;
        pkt_idx = '0;
        for (int r = 0; r < NRANK; r++) begin
            if (!pkt_hit && kinds[RANK[r]]) begin
                pkt_hit = 1'b1;
                pkt_idx = RANK[r];
            end
        end
        if (pkt_hit) begin
            keep[pkt_idx] = 1'b1;
        end
    end
endmodule

// File: rtl/fel_hdr_log.sv
module fel_hdr_log
    import fel_pkg::*;
#(
    parameter int HW = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [NKIND-1:0] keep,
    input  logic             pkt_hit,
    input  logic [KW-1:0]    pkt_idx,
    input  logic             psn_raw,
    input  logic             on_link,
    input  logic [HW-1:0]    hdr_in,
    input  logic             clr_we,
    input  logic [NKIND-1:0] clr_mask,
    input  logic             dpe_clr,
    output logic [NKIND-1:0] sts,
    output logic             dpe,
    output logic             hdr_valid,
    output logic [KW-1:0]    first_err,
    output logic [HW-1:0]    hdr_log
);
    typedef struct packed {
        logic [NKIND-1:0] sts;
        logic             dpe;
        logic             hv;
        logic [KW-1:0]    fe;
        logic [HW-1:0]    hdr;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clr_we) begin
            log_d.sts = log_q.sts & ~clr_mask;
            if (log_q.hv && clr_mask[log_q.fe]) begin
                log_d.hv = 1'b0;
            end
        end
        if (dpe_clr) begin
            log_d.dpe = 1'b0;
        end
        if (ev_valid) begin
            log_d.sts = log_d.sts | keep;
            if (psn_raw) begin
                log_d.dpe = 1'b1;
            end
            if (!log_q.hv) begin
                if (pkt_hit && on_link) begin
                    log_d.hv  = 1'b1;
                    log_d.fe  = pkt_idx;
                    log_d.hdr = hdr_in;
                end else if (keep[K_INT]) begin
                    log_d.hv  = 1'b1;
                    log_d.fe  = K_INT;
                    log_d.hdr = '1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

    assign sts       = log_q.sts;
    assign dpe       = log_q.dpe;
    assign hdr_valid = log_q.hv;
    assign first_err = log_q.fe;
    assign hdr_log   = log_q.hdr;

    p_one_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $onehot0(keep & PKT_MASK));

    p_nopkt_every_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && keep[K_CTO] |=> log_q.sts[K_CTO]);

    p_hdr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        log_q.hv && $past(log_q.hv) |-> $stable(log_q.hdr) && $stable(log_q.fe));

    p_offlink_nohdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !log_q.hv && ev_valid && !on_link && !keep[K_INT] |=> !log_q.hv);

    p_int_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        log_q.hv && log_q.fe == K_INT |-> &log_q.hdr);

    p_dpe_poison_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && psn_raw |=> log_q.dpe);
endmodule

// File: rtl/fel_chan.sv
module fel_chan
    import fel_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpl_valid,
    input  logic [1:0]     cpl_status,
    input  logic [CW-1:0]  cpl_chan,
    input  logic           cpl_kind,
    input  logic [NCH-1:0] start,
    input  logic           clr_we,
    input  logic [CW-1:0]  clr_sel,
    input  logic [1:0]     clr_mask,
    output logic [NCH-1:0] busy,
    output logic [NCH-1:0] desc_ca,
    output logic [NCH-1:0] data_ca
);
    typedef struct packed {
        logic [NCH-1:0] busy;
        logic [NCH-1:0] dca;
        logic [NCH-1:0] uca;
    } ch_t;

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        for (int i = 0; i < NCH; i++) begin
            logic hit, ab_desc, ab_data;
            hit     = cpl_valid && (cpl_chan == CW'(i)) && ch_q.busy[i];
            ab_desc = hit && (cpl_status == CPL_CA) && (cpl_kind == RD_DESC);
            ab_data = hit && (cpl_status == CPL_UR) && (cpl_kind == RD_DATA);
            if (clr_we && (clr_sel == CW'(i))) begin
                if (clr_mask[0]) ch_d.dca[i] = 1'b0;
                if (clr_mask[1]) ch_d.uca[i] = 1'b0;
            end
            if (ab_desc) ch_d.dca[i] = 1'b1;
            if (ab_data) ch_d.uca[i] = 1'b1;
            if (ab_desc || ab_data) begin
                ch_d.busy[i] = 1'b0;
            end else if (start[i] && !ch_q.dca[i] && !ch_q.uca[i]) begin
                ch_d.busy[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign busy    = ch_q.busy;
    assign desc_ca = ch_q.dca;
    assign data_ca = ch_q.uca;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_desc_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cpl_valid && cpl_chan == CW'(g) && ch_q.busy[g] && cpl_status == CPL_CA
            && cpl_kind == RD_DESC |=> ch_q.dca[g] && !ch_q.busy[g]);

        p_data_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cpl_valid && cpl_chan == CW'(g) && ch_q.busy[g] && cpl_status == CPL_UR
            && cpl_kind == RD_DATA |=> ch_q.uca[g] && !ch_q.busy[g]);

        p_ok_keeps_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
            cpl_valid && cpl_chan == CW'(g) && ch_q.busy[g] && cpl_status == CPL_SC
            |=> ch_q.busy[g]);

        p_abort_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_q.dca[g] || ch_q.uca[g]) |-> !ch_q.busy[g]);
    end
endmodule

// File: rtl/fn_err_log.sv
module fn_err_log
    import fel_pkg::*;
#(
    parameter int NCH = 4,
    parameter int HW  = 128,
    parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [NKIND-1:0] ev_kind,
    input  logic             ev_on_link,
    input  logic [HW-1:0]    ev_hdr,
    input  logic             aer_clr_we,
    input  logic [NKIND-1:0] aer_clr_mask,
    input  logic             dpe_clr,
    input  logic             cpl_valid,
    input  logic [1:0]       cpl_status,
    input  logic [CW-1:0]    cpl_chan,
    input  logic             cpl_kind,
    input  logic [NCH-1:0]   ch_start,
    input  logic             ch_clr_we,
    input  logic [CW-1:0]    ch_clr_sel,
    input  logic [1:0]       ch_clr_mask,
    output logic [NKIND-1:0] aer_sts,
    output logic             dpe,
    output logic             hdr_valid,
    output logic [KW-1:0]    first_err,
    output logic [HW-1:0]    hdr_log,
    output logic [NCH-1:0]   ch_busy,
    output logic [NCH-1:0]   ch_desc_ca,
    output logic [NCH-1:0]   ch_data_ca
);
    logic [NKIND-1:0] keep;
    logic             pkt_hit;
    logic [KW-1:0]    pkt_idx;

    fel_pollute u_pollute (
        .kinds   (ev_kind),
        .keep    (keep),
        .pkt_hit (pkt_hit),
        .pkt_idx (pkt_idx)
    );

    fel_hdr_log #(.HW(HW)) u_hdr_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .keep      (keep),
        .pkt_hit   (pkt_hit),
        .pkt_idx   (pkt_idx),
        .psn_raw   (ev_kind[K_PSN]),
        .on_link   (ev_on_link),
        .hdr_in    (ev_hdr),
        .clr_we    (aer_clr_we),
        .clr_mask  (aer_clr_mask),
        .dpe_clr   (dpe_clr),
        .sts       (aer_sts),
        .dpe       (dpe),
        .hdr_valid (hdr_valid),
        .first_err (first_err),
        .hdr_log   (hdr_log)
    );

    fel_chan #(.NCH(NCH), .CW(CW)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpl_valid  (cpl_valid),
        .cpl_status (cpl_status),
        .cpl_chan   (cpl_chan),
        .cpl_kind   (cpl_kind),
        .start      (ch_start),
        .clr_we     (ch_clr_we),
        .clr_sel    (ch_clr_sel),
        .clr_mask   (ch_clr_mask),
        .busy       (ch_busy),
        .desc_ca    (ch_desc_ca),
        .data_ca    (ch_data_ca)
    );
endmodule

// File: tb/fn_err_log_bench.sv
module fn_err_log_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int HW  = 128;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic ev_valid, ev_on_link, aer_clr_we, dpe_clr, cpl_valid, cpl_kind, ch_clr_we;
    logic [6:0] ev_kind, aer_clr_mask;
    logic [HW-1:0] ev_hdr;
    logic [1:0] cpl_status, ch_clr_mask;
    logic [CW-1:0] cpl_chan, ch_clr_sel;
    logic [NCH-1:0] ch_start;
    logic [6:0] aer_sts;
    logic dpe, hdr_valid;
    logic [2:0] first_err;
    logic [HW-1:0] hdr_log;
    logic [NCH-1:0] ch_busy, ch_desc_ca, ch_data_ca;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [6:0] m_sts;
    logic m_dpe, m_hv;
    logic [2:0] m_fe;
    logic [HW-1:0] m_hdr;
    logic [NCH-1:0] m_busy, m_dca, m_uca;

    always #(CLK_PERIOD/2) clk = ~clk;

    fn_err_log #(.NCH(NCH), .HW(HW)) u_fn_err_log (.*);

    task automatic idle();
        ev_valid = 0; ev_kind = '0; ev_on_link = 0; ev_hdr = '0;
        aer_clr_we = 0; aer_clr_mask = '0; dpe_clr = 0;
        cpl_valid = 0; cpl_status = '0; cpl_chan = '0; cpl_kind = 0;
        ch_start = '0; ch_clr_we = 0; ch_clr_sel = '0; ch_clr_mask = '0;
    endtask

    task automatic chk(string req, string what, logic [HW-1:0] act, logic [HW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] pick(input logic [6:0] k, output logic hit, output logic [2:0] idx);
        int ord [5] = '{4, 3, 0, 1, 2};
        logic [6:0] kp;
        kp = k & 7'b1100000;
        hit = 0; idx = '0;
        for (int r = 0; r < 5; r++) begin
            if (!hit && k[ord[r]]) begin hit = 1; idx = 3'(ord[r]); end
        end
        if (hit) kp[idx] = 1'b1;
        return kp;
    endfunction

    task automatic tick(string req);
        logic [6:0] n_sts, kp;
        logic n_dpe, n_hv, hit;
        logic [2:0] n_fe, widx;
        logic [HW-1:0] n_hdr;
        logic [NCH-1:0] n_busy, n_dca, n_uca;
        n_sts = m_sts; n_dpe = m_dpe; n_hv = m_hv; n_fe = m_fe; n_hdr = m_hdr;
        n_busy = m_busy; n_dca = m_dca; n_uca = m_uca;
        kp = pick(ev_kind, hit, widx);
        if (aer_clr_we) begin
            n_sts = m_sts & ~aer_clr_mask;
            if (m_hv && aer_clr_mask[m_fe]) n_hv = 0;
        end
        if (dpe_clr) n_dpe = 0;
        if (ev_valid) begin
            n_sts = n_sts | kp;
            if (ev_kind[2]) n_dpe = 1;
            if (!m_hv) begin
                if (hit && ev_on_link) begin n_hv = 1; n_fe = widx; n_hdr = ev_hdr; end
                else if (kp[6]) begin n_hv = 1; n_fe = 3'd6; n_hdr = '1; end
            end
        end
        for (int i = 0; i < NCH; i++) begin
            logic h, ad, au;
            h  = cpl_valid && cpl_chan == CW'(i) && m_busy[i];
            ad = h && cpl_status == 2'd2 && cpl_kind == 1'b0;
            au = h && cpl_status == 2'd1 && cpl_kind == 1'b1;
            if (ch_clr_we && ch_clr_sel == CW'(i)) begin
                if (ch_clr_mask[0]) n_dca[i] = 0;
                if (ch_clr_mask[1]) n_uca[i] = 0;
            end
            if (ad) n_dca[i] = 1;
            if (au) n_uca[i] = 1;
            if (ad || au) n_busy[i] = 0;
            else if (ch_start[i] && !m_dca[i] && !m_uca[i]) n_busy[i] = 1;
        end
        @(posedge clk); #1;
        m_sts = n_sts; m_dpe = n_dpe; m_hv = n_hv; m_fe = n_fe; m_hdr = n_hdr;
        m_busy = n_busy; m_dca = n_dca; m_uca = n_uca;
        chk(req, "aer_sts", HW'(aer_sts), HW'(m_sts));
        chk(req, "dpe", HW'(dpe), HW'(m_dpe));
        chk(req, "hdr_valid", HW'(hdr_valid), HW'(m_hv));
        if (m_hv) begin
            chk(req, "first_err", HW'(first_err), HW'(m_fe));
            chk(req, "hdr_log", hdr_log, m_hdr);
        end
        chk(req, "ch_busy", HW'(ch_busy), HW'(m_busy));
        chk(req, "ch_desc_ca", HW'(ch_desc_ca), HW'(m_dca));
        chk(req, "ch_data_ca", HW'(ch_data_ca), HW'(m_uca));
        @(negedge clk);
        idle();
    endtask

    function automatic logic [HW-1:0] rnd_hdr();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        idle();
        rst_n = 0;
        m_sts = '0; m_dpe = 0; m_hv = 0; m_fe = '0; m_hdr = '0;
        m_busy = '0; m_dca = '0; m_uca = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        tick("R1 reset");

        // R2 R4 R7: stacked UR+UC+PSN on link
        ev_valid = 1; ev_kind = 7'b0000111; ev_on_link = 1; ev_hdr = 128'hA5A5_0001_0002_0003_0004_0005_0006_0007;
        tick("R2 R4 R7 pollution");
        // R4: second error does not overwrite header
        ev_valid = 1; ev_kind = 7'b0010000; ev_on_link = 1; ev_hdr = rnd_hdr();
        tick("R4 hold");
        // R14 R8: clear first error frees slot
        aer_clr_we = 1; aer_clr_mask = 7'b0000001; dpe_clr = 1;
        tick("R14 R8 R7 clear");
        // R5: off-link UC logs no header
        ev_valid = 1; ev_kind = 7'b0000010; ev_on_link = 0; ev_hdr = rnd_hdr();
        tick("R5 offlink");
        // R3 R5: completion timeout with a poisoned packet off link
        ev_valid = 1; ev_kind = 7'b0100100; ev_on_link = 0; ev_hdr = rnd_hdr();
        tick("R3 R5 timeout");
        ev_valid = 1; ev_kind = 7'b0100000; ev_on_link = 1;
        tick("R3 R5 timeout repeat");
        // R6: internal error fills ones
        aer_clr_we = 1; aer_clr_mask = 7'h7f;
        tick("R8 clear all");
        ev_valid = 1; ev_kind = 7'b1000000; ev_on_link = 1; ev_hdr = rnd_hdr();
        tick("R6 internal");
        // R8: set and clear same bit same cycle
        aer_clr_we = 1; aer_clr_mask = 7'b0001000; ev_valid = 1; ev_kind = 7'b0001000;
        tick("R8 set wins");
        aer_clr_we = 1; aer_clr_mask = 7'h7f;
        tick("R14 R8 clear");
        // R2: ECRC beats UR, on link captures ECRC index
        ev_valid = 1; ev_kind = 7'b0001101; ev_on_link = 1; ev_hdr = rnd_hdr();
        tick("R2 R4 ecrc rank");

        // Channels
        ch_start = 4'b0111; tick("R9 start");
        cpl_valid = 1; cpl_chan = 0; cpl_status = 2'd2; cpl_kind = 0; tick("R10 desc abort");
        cpl_valid = 1; cpl_chan = 1; cpl_status = 2'd1; cpl_kind = 1; tick("R11 data abort");
        cpl_valid = 1; cpl_chan = 2; cpl_status = 2'd2; cpl_kind = 1; tick("R12 ca on data");
        cpl_valid = 1; cpl_chan = 2; cpl_status = 2'd1; cpl_kind = 0; tick("R12 ur on desc");
        cpl_valid = 1; cpl_chan = 2; cpl_status = 2'd0; cpl_kind = 0; tick("R12 success");
        cpl_valid = 1; cpl_chan = 3; cpl_status = 2'd2; cpl_kind = 0; tick("R12 idle chan");
        ch_start = 4'b0001; tick("R13 restart blocked");
        ch_clr_we = 1; ch_clr_sel = 0; ch_clr_mask = 2'b10; tick("R13 wrong mask");
        ch_start = 4'b0001; tick("R13 still blocked");
        ch_clr_we = 1; ch_clr_sel = 0; ch_clr_mask = 2'b01; tick("R13 clear");
        ch_start = 4'b0001; tick("R9 R13 restart");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            ev_valid   = ($urandom % 2) == 0;
            ev_kind    = 7'($urandom) & 7'($urandom);
            ev_on_link = ($urandom % 4) != 0;
            ev_hdr     = rnd_hdr();
            aer_clr_we = ($urandom % 6) == 0;
            aer_clr_mask = 7'($urandom);
            dpe_clr    = ($urandom % 8) == 0;
            cpl_valid  = ($urandom % 2) == 0;
            cpl_status = 2'($urandom % 3);
            cpl_chan   = CW'($urandom);
            cpl_kind   = 1'($urandom);
            ch_start   = NCH'($urandom);
            ch_clr_we  = ($urandom % 4) == 0;
            ch_clr_sel = CW'($urandom);
            ch_clr_mask = 2'($urandom);
            tick("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 R14 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule